// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Fetch Address Controller

This block owns the fetch program counter and the IF/ID pipeline register of a five-stage in-order pipeline whose conditional branches are settled in the decode stage. The instruction sitting in ID is decoded by the caller into a small control operation. The block receives that operation with the two source operands, already forwarded, and the two candidate targets. It then decides in the same cycle whether fetch is redirected. A taken branch therefore costs a single fetch slot. Once resolved, a branch carries no further work down the pipe.

A per-cycle mode input picks how that slot is treated. In flush mode the block predicts not-taken, keeps fetching sequentially, and turns the wrongly fetched instruction into a bubble on redirect. In delay-slot mode the instruction behind every branch or jump always proceeds. For jump-and-link the block produces the link register index and the return address. That address skips the delay slot in delay-slot mode, and returns to the next word in flush mode, where that word has been squashed.

Top module: `decode_redirect`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals the parameter RESET_PC, `ifid_valid_o` and `ifid_wen_o` are 0, and `if_flush_o` is 0.
- R2: With no stall and no redirect, `pc_o` grows by 4 on every clock edge, and IF/ID captures `if_instr_i`, the current `pc_o`, valid = 1 and `if_wen_i`.
- R3: When `stall_i` is 1, `pc_o` and all IF/ID outputs keep their values across the edge, and `if_flush_o` is 0.
- R4: With `ifid_valid_o` = 1, operation code 1 (branch-if-equal) raises `redirect_o` exactly when `opnd_a_i == opnd_b_i`. Operation code 2 (branch-if-not-equal) raises it exactly when they differ. In both cases `next_pc_o` is then `br_target_i`.
- R5: With `ifid_valid_o` = 1, operation codes 3 (jump) and 4 (jump-and-link) always raise `redirect_o`, and `next_pc_o` is `jmp_target_i`.
- R6: Without redirect `next_pc_o` is `pc_o + 4`. On any unstalled edge `pc_o` takes the value `next_pc_o` had before the edge, so a redirect costs exactly one fetch slot.
- R7: In flush mode (`slot_mode_i` = 0), `if_flush_o` equals `redirect_o & ~stall_i`. After a flushing edge, IF/ID holds valid = 0, write-enable = 0 and an all-zero instruction word.
- R8: In delay-slot mode (`slot_mode_i` = 1), `if_flush_o` stays 0. The instruction fetched alongside a redirecting branch enters IF/ID with valid = 1 and its own write-enable.
- R9: For operation code 4 with a valid ID slot, `link_we_o` is 1 and `link_reg_o` is 31. `link_data_o` is `ifid_pc_o + 8` in delay-slot mode and `ifid_pc_o + 4` in flush mode.
- R10: Operation code 0, codes 5 to 7, or `ifid_valid_o` = 0 cause no redirect and no link write. Branch codes 1 and 2 never raise `link_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Hold PC and IF/ID this cycle |
| slot_mode_i | input | 1 | 0 = predict not-taken with flush, 1 = delay slot |
| if_instr_i | input | IW | Instruction word fetched at `pc_o` |
| if_wen_i | input | 1 | Register write enable predecoded for the fetched word |
| id_op_i | input | 3 | Control operation of the ID instruction (0 none, 1 beq, 2 bne, 3 jump, 4 jump-and-link) |
| opnd_a_i | input | DW | First compare operand (forwarded) |
| opnd_b_i | input | DW | Second compare operand (forwarded) |
| br_target_i | input | AW | Conditional branch target |
| jmp_target_i | input | AW | Jump target |
| pc_o | output | AW | Current fetch address |
| next_pc_o | output | AW | Fetch address for the next cycle |
| if_flush_o | output | 1 | Squash the instruction now in IF |
| redirect_o | output | 1 | Control transfer taken in ID |
| ifid_instr_o | output | IW | IF/ID instruction word |
| ifid_pc_o | output | AW | IF/ID instruction address |
| ifid_valid_o | output | 1 | IF/ID valid bit |
| ifid_wen_o | output | 1 | IF/ID register write enable |
| link_we_o | output | 1 | Write the link value |
| link_reg_o | output | RW | Link register index |
| link_data_o | output | AW | Return address to write |

## Verification
`redirect_o`, `next_pc_o`, `if_flush_o` and the link outputs are combinational from the ID contents and the inputs, so they are due in the same cycle and are sampled one time unit after the inputs change at the falling edge. `pc_o` and the IF/ID outputs are due one rising edge later. The bench predicts them from its own model of the previous cycle's decision and samples them at the next falling edge. Each of those checks is tagged with the cause that produced it: a sequential step, a stall, a redirect, a flush or a delay slot.

// File: rtl/decode_redirect_pkg.sv
package decode_redirect_pkg;

   // control operation presented by the decoder for the instruction in ID
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_BEQ  = 3'd1,
      OP_BNE  = 3'd2,
      OP_JMP  = 3'd3,
      OP_JAL  = 3'd4
   } ctl_op_e;

   // bytes per instruction word
   localparam int unsigned WORD_BYTES = 4;

   // comparator implementation variants
   localparam int unsigned CMP_DIRECT = 0;
   localparam int unsigned CMP_XOR    = 1;

endpackage

// File: rtl/dr_compare.sv
module dr_compare #(
   parameter int unsigned DW    = 32,
   parameter int unsigned STYLE = decode_redirect_pkg::CMP_DIRECT
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic          eq_o
);
   import decode_redirect_pkg::*;

   if (DW < 1) begin : g_bad_dw
      $error("dr_compare: DW must be at least 1");
   end

   if (STYLE == CMP_XOR) begin : g_xor
      logic [DW-1:0] diff;
      always_comb begin
         diff = a_i ^ b_i;
         eq_o = ~|diff;
      end
   end else begin : g_direct
      always_comb eq_o = (a_i == b_i);
   end

endmodule

// File: rtl/dr_decide.sv
module dr_decide #(
   parameter int unsigned AW       = 32,
   parameter int unsigned RW       = 5,
   parameter int unsigned LINK_REG = 31
) (
   input  logic          valid_i,
   input  logic [2:0]    op_i,
   input  logic          eq_i,
   input  logic          slot_mode_i,
   input  logic [AW-1:0] id_pc_i,
   input  logic [AW-1:0] br_target_i,
   input  logic [AW-1:0] jmp_target_i,
   output logic          redirect_o,
   output logic [AW-1:0] target_o,
   output logic          link_we_o,
   output logic [RW-1:0] link_reg_o,
   output logic [AW-1:0] link_data_o
);
   import decode_redirect_pkg::*;

   localparam logic [AW-1:0] STEP_ONE = AW'(WORD_BYTES);
   localparam logic [AW-1:0] STEP_TWO = AW'(2 * WORD_BYTES);

   if (LINK_REG >= (1 << RW)) begin : g_bad_link
      $error("dr_decide: LINK_REG does not fit in RW bits");
   end

   logic take_cond;
   logic take_jump;
   logic is_jal;

   always_comb begin
      take_cond = 1'b0;
      take_jump = 1'b0;
      is_jal    = 1'b0;
      if (valid_i) begin
         unique case (op_i)
            OP_BEQ:  take_cond = eq_i;
            OP_BNE:  take_cond = ~eq_i;
            OP_JMP:  take_jump = 1'b1;
            OP_JAL: begin
               take_jump = 1'b1;
               is_jal    = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      redirect_o  = take_cond | take_jump;
      target_o    = take_jump ? jmp_target_i : br_target_i;
      link_we_o   = is_jal;
      link_reg_o  = RW'(LINK_REG);
      // the delay slot executes, so the return must step over it
      link_data_o = id_pc_i + (slot_mode_i ? STEP_TWO : STEP_ONE);
   end

endmodule

// File: rtl/dr_pcgen.sv
module dr_pcgen #(
   parameter int unsigned   AW       = 32,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_i,
   input  logic          redirect_i,
   input  logic [AW-1:0] target_i,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] next_pc_o
);
   import decode_redirect_pkg::*;

   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   if (AW < 3) begin : g_bad_aw
      $error("dr_pcgen: AW must be at least 3");
   end

   logic [AW-1:0] seq_pc;

   always_comb begin
      seq_pc    = pc_o + STEP;
      next_pc_o = redirect_i ? target_i : seq_pc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o <= RESET_PC;
      end else if (!stall_i) begin
         pc_o <= next_pc_o;
      end
   end

endmodule

// File: rtl/dr_ifid.sv
module dr_ifid #(
   parameter int unsigned IW = 32,
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_i,
   input  logic          flush_i,
   input  logic [IW-1:0] instr_i,
   input  logic [AW-1:0] pc_i,
   input  logic          wen_i,
   output logic [IW-1:0] instr_o,
   output logic [AW-1:0] pc_o,
   output logic          valid_o,
   output logic          wen_o
);

   if (IW < 1) begin : g_bad_iw
      $error("dr_ifid: IW must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         instr_o <= '0;
         pc_o    <= '0;
         valid_o <= 1'b0;
         wen_o   <= 1'b0;
      end else if (!stall_i) begin
         pc_o <= pc_i;
         if (flush_i) begin
            instr_o <= '0;
            valid_o <= 1'b0;
            wen_o   <= 1'b0;
         end else begin
            instr_o <= instr_i;
            valid_o <= 1'b1;
            wen_o   <= wen_i;
         end
      end
   end

endmodule

// File: rtl/decode_redirect.sv
module decode_redirect #(
   parameter int unsigned   AW        = 32,
   parameter int unsigned   DW        = 32,
   parameter int unsigned   IW        = 32,
   parameter int unsigned   NREGS     = 32,
   parameter int unsigned   LINK_REG  = 31,
   parameter int unsigned   CMP_STYLE = decode_redirect_pkg::CMP_DIRECT,
   parameter logic [AW-1:0] RESET_PC  = AW'(32'h0000_0100),
   localparam int unsigned  RW        = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_i,
   input  logic          slot_mode_i,
   input  logic [IW-1:0] if_instr_i,
   input  logic          if_wen_i,
   input  logic [2:0]    id_op_i,
   input  logic [DW-1:0] opnd_a_i,
   input  logic [DW-1:0] opnd_b_i,
   input  logic [AW-1:0] br_target_i,
   input  logic [AW-1:0] jmp_target_i,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] next_pc_o,
   output logic          if_flush_o,
   output logic          redirect_o,
   output logic [IW-1:0] ifid_instr_o,
   output logic [AW-1:0] ifid_pc_o,
   output logic          ifid_valid_o,
   output logic          ifid_wen_o,
   output logic          link_we_o,
   output logic [RW-1:0] link_reg_o,
   output logic [AW-1:0] link_data_o
);

   if (NREGS < 2) begin : g_bad_nregs
      $error("decode_redirect: NREGS must be at least 2");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
      $error("decode_redirect: RESET_PC must be word aligned");
   end

   logic          ops_equal;
   logic [AW-1:0] sel_target;

   dr_compare #(
      .DW    (DW),
      .STYLE (CMP_STYLE)
   ) u_cmp (
      .a_i  (opnd_a_i),
      .b_i  (opnd_b_i),
      .eq_o (ops_equal)
   );

   dr_decide #(
      .AW       (AW),
      .RW       (RW),
      .LINK_REG (LINK_REG)
   ) u_decide (
      .valid_i      (ifid_valid_o),
      .op_i         (id_op_i),
      .eq_i         (ops_equal),
      .slot_mode_i  (slot_mode_i),
      .id_pc_i      (ifid_pc_o),
      .br_target_i  (br_target_i),
      .jmp_target_i (jmp_target_i),
      .redirect_o   (redirect_o),
      .target_o     (sel_target),
      .link_we_o    (link_we_o),
      .link_reg_o   (link_reg_o),
      .link_data_o  (link_data_o)
   );

   dr_pcgen #(
      .AW       (AW),
      .RESET_PC (RESET_PC)
   ) u_pcgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall_i    (stall_i),
      .redirect_i (redirect_o),
      .target_i   (sel_target),
      .pc_o       (pc_o),
      .next_pc_o  (next_pc_o)
   );

   // squash the wrong-path fetch only when the edge actually advances
   always_comb if_flush_o = redirect_o & ~slot_mode_i & ~stall_i;

   dr_ifid #(
      .IW (IW),
      .AW (AW)
   ) u_ifid (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall_i (stall_i),
      .flush_i (if_flush_o),
      .instr_i (if_instr_i),
      .pc_i    (pc_o),
      .wen_i   (if_wen_i),
      .instr_o (ifid_instr_o),
      .pc_o    (ifid_pc_o),
      .valid_o (ifid_valid_o),
      .wen_o   (ifid_wen_o)
   );

endmodule

// File: rtl/decode_redirect_chk.sv
module decode_redirect_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned IW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stall_i,
   input logic          slot_mode_i,
   input logic [AW-1:0] pc_o,
   input logic [AW-1:0] next_pc_o,
   input logic          if_flush_o,
   input logic          redirect_o,
   input logic [IW-1:0] ifid_instr_o,
   input logic          ifid_valid_o,
   input logic          ifid_wen_o,
   input logic          link_we_o
);

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> ($stable(pc_o) && $stable(ifid_valid_o) && $stable(ifid_instr_o)));

   // R6
   pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_i |=> (pc_o == $past(next_pc_o)));

   // R7
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      if_flush_o |-> (redirect_o && !slot_mode_i && !stall_i));

   // R7
   flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      if_flush_o |=> (!ifid_valid_o && !ifid_wen_o && ifid_instr_o == '0));

   // R8
   slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_mode_i && redirect_o && !stall_i) |=> ifid_valid_o);

   // R10
   link_needs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> (redirect_o && ifid_valid_o));

endmodule

bind decode_redirect decode_redirect_chk #(
   .AW (AW),
   .IW (IW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall_i      (stall_i),
   .slot_mode_i  (slot_mode_i),
   .pc_o         (pc_o),
   .next_pc_o    (next_pc_o),
   .if_flush_o   (if_flush_o),
   .redirect_o   (redirect_o),
   .ifid_instr_o (ifid_instr_o),
   .ifid_valid_o (ifid_valid_o),
   .ifid_wen_o   (ifid_wen_o),
   .link_we_o    (link_we_o)
);

// File: tb/decode_redirect_tb.sv
module decode_redirect_tb;

   localparam int unsigned   AW  = 32;
   localparam int unsigned   DW  = 32;
   localparam int unsigned   IW  = 32;
   localparam logic [AW-1:0] RPC = 32'h0000_0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall_i = 1'b0;
   logic          slot_mode_i = 1'b0;
   logic [IW-1:0] if_instr_i = '0;
   logic          if_wen_i = 1'b0;
   logic [2:0]    id_op_i = '0;
   logic [DW-1:0] opnd_a_i = '0;
   logic [DW-1:0] opnd_b_i = '0;
   logic [AW-1:0] br_target_i = '0;
   logic [AW-1:0] jmp_target_i = '0;
   logic [AW-1:0] pc_o, next_pc_o, ifid_pc_o, link_data_o;
   logic          if_flush_o, redirect_o, ifid_valid_o, ifid_wen_o, link_we_o;
   logic [IW-1:0] ifid_instr_o;
   logic [4:0]    link_reg_o;

   decode_redirect #(.AW(AW), .DW(DW), .IW(IW), .RESET_PC(RPC)) u_dut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .slot_mode_i(slot_mode_i),
      .if_instr_i(if_instr_i), .if_wen_i(if_wen_i), .id_op_i(id_op_i),
      .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .br_target_i(br_target_i),
      .jmp_target_i(jmp_target_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
      .if_flush_o(if_flush_o), .redirect_o(redirect_o), .ifid_instr_o(ifid_instr_o),
      .ifid_pc_o(ifid_pc_o), .ifid_valid_o(ifid_valid_o), .ifid_wen_o(ifid_wen_o),
      .link_we_o(link_we_o), .link_reg_o(link_reg_o), .link_data_o(link_data_o)
   );

   always #4 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;

   // bench model of the registered state
   logic [AW-1:0] m_pc;
   logic [IW-1:0] m_instr;
   logic [AW-1:0] m_ipc;
   logic          m_valid, m_wen;
   string         pc_tag, ifid_tag;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_taken(input logic v, input logic [2:0] op,
                                      input logic [DW-1:0] a, input logic [DW-1:0] b);
      if (!v) return 1'b0;
      case (op)
         3'd1:    return a == b;
         3'd2:    return a != b;
         3'd3,
         3'd4:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string op_tag(input logic v, input logic [2:0] op);
      if (!v || op == 3'd0 || op > 3'd4) return "R10";
      if (op <= 3'd2) return "R4";
      return "R5";
   endfunction

   // inputs are set at the falling edge before this is called
   task automatic run_cycle();
      logic          tk, fl;
      logic [AW-1:0] npc;
      #1;
      check(pc_tag, "pc_o", 64'(pc_o), 64'(m_pc));
      check(ifid_tag, "ifid_valid_o", 64'(ifid_valid_o), 64'(m_valid));
      check(ifid_tag, "ifid_wen_o", 64'(ifid_wen_o), 64'(m_wen));
      check(ifid_tag, "ifid_instr_o", 64'(ifid_instr_o), 64'(m_instr));
      check(ifid_tag, "ifid_pc_o", 64'(ifid_pc_o), 64'(m_ipc));
      tk  = exp_taken(m_valid, id_op_i, opnd_a_i, opnd_b_i);
      npc = !tk ? m_pc + 32'd4 : ((id_op_i >= 3'd3) ? jmp_target_i : br_target_i);
      fl  = tk && !slot_mode_i && !stall_i;
      check(op_tag(m_valid, id_op_i), "redirect_o", 64'(redirect_o), 64'(tk));
      check(tk ? op_tag(m_valid, id_op_i) : "R6", "next_pc_o", 64'(next_pc_o), 64'(npc));
      check(stall_i ? "R3" : (slot_mode_i ? "R8" : "R7"), "if_flush_o",
            64'(if_flush_o), 64'(fl));
      if (m_valid && id_op_i == 3'd4) begin
         check("R9", "link_we_o", 64'(link_we_o), 64'd1);
         check("R9", "link_reg_o", 64'(link_reg_o), 64'd31);
         check("R9", "link_data_o", 64'(link_data_o),
               64'(m_ipc + (slot_mode_i ? 32'd8 : 32'd4)));
      end else begin
         check("R10", "link_we_o", 64'(link_we_o), 64'd0);
      end
      @(posedge clk);
      if (stall_i) begin
         pc_tag   = "R3";
         ifid_tag = "R3";
      end else begin
         pc_tag = tk ? "R6" : "R2";
         if (fl) begin
            ifid_tag = "R7";
            m_instr  = '0;
            m_valid  = 1'b0;
            m_wen    = 1'b0;
         end else begin
            ifid_tag = (tk && slot_mode_i) ? "R8" : "R2";
            m_instr  = if_instr_i;
            m_valid  = 1'b1;
            m_wen    = if_wen_i;
         end
         m_ipc = m_pc;
         m_pc  = npc;
      end
      @(negedge clk);
   endtask

   task automatic drive(input logic st, input logic md, input logic [2:0] op,
                        input logic [DW-1:0] a, input logic [DW-1:0] b);
      stall_i      = st;
      slot_mode_i  = md;
      id_op_i      = op;
      opnd_a_i     = a;
      opnd_b_i     = b;
      if_instr_i   = $urandom;
      if_wen_i     = 1'($urandom);
      br_target_i  = $urandom & 32'hFFFF_FFFC;
      jmp_target_i = $urandom & 32'hFFFF_FFFC;
      run_cycle();
   endtask

   initial begin
      #(8 * 150000);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'd61));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1", "pc_o", 64'(pc_o), 64'(RPC));
      check("R1", "ifid_valid_o", 64'(ifid_valid_o), 64'd0);
      check("R1", "ifid_wen_o", 64'(ifid_wen_o), 64'd0);
      check("R1", "if_flush_o", 64'(if_flush_o), 64'd0);
      @(negedge clk);
      rst_n    = 1'b1;
      m_pc     = RPC;
      m_instr  = '0;
      m_ipc    = '0;
      m_valid  = 1'b0;
      m_wen    = 1'b0;
      pc_tag   = "R2";
      ifid_tag = "R2";
      // branch codes with an empty ID slot: no redirect (R10)
      drive(1'b0, 1'b0, 3'd3, 32'd0, 32'd0);
      drive(1'b0, 1'b0, 3'd0, 32'd0, 32'd0);
      // R4 equal / unequal, flush mode
      drive(1'b0, 1'b0, 3'd1, 32'h55, 32'h55);
      drive(1'b0, 1'b0, 3'd0, 32'd0, 32'd0);
      drive(1'b0, 1'b0, 3'd1, 32'h55, 32'h56);
      drive(1'b0, 1'b0, 3'd2, 32'h55, 32'h56);
      drive(1'b0, 1'b0, 3'd0, 32'd0, 32'd0);
      // R3 stall with a taken branch, then release
      drive(1'b1, 1'b0, 3'd2, 32'h1, 32'h2);
      drive(1'b0, 1'b0, 3'd2, 32'h1, 32'h2);
      drive(1'b0, 1'b1, 3'd0, 32'd0, 32'd0);
      // R8 delay slot keeps the next fetch
      drive(1'b0, 1'b1, 3'd1, 32'h7, 32'h7);
      // R9 link in both modes; reserved codes (R10)
      drive(1'b0, 1'b1, 3'd4, 32'd0, 32'd0);
      drive(1'b0, 1'b0, 3'd0, 32'd0, 32'd0);
      drive(1'b0, 1'b0, 3'd4, 32'd0, 32'd0);
      drive(1'b0, 1'b1, 3'd0, 32'd0, 32'd0);
      drive(1'b0, 1'b1, 3'd6, 32'h3, 32'h3);
      drive(1'b0, 1'b1, 3'd7, 32'h3, 32'h4);
      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic [DW-1:0] a, b;
         logic [2:0]    op;
         a  = $urandom;
         b  = ($urandom % 2) ? a : $urandom;
         op = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
         drive(($urandom % 5) == 0, (i / 500) % 2 == 1 ? 1'b1 : 1'($urandom % 4 == 0),
               op, a, b);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule